// File: doc/BRIEF.md
# Multichannel ADC serial readout controller

This block sits on the host side of an eight-channel scanning converter. A one-cycle start request begins a frame. The block raises the conversion pulse, waits until the conversion has finished, and then pulls chip select low. It clocks the results out with a divided serial clock and stores each 16-bit channel word in its own output register. When the frame is complete, a valid strobe pulses for one cycle.

During the first 16 serial clocks of every frame the block shifts a 16-bit configuration word out on the data-in line, most significant bit first. The converter holds this word in a pending stage. It loads the word into its working register at the end of the next conversion, so the word takes effect on the conversion after that one. When readback is enabled, one extra 16-bit word follows the channel words. That word is the configuration the converter used for the conversion just read, and the block presents it on its own output.

In single-line mode all eight channels come in over SDO, and the end of conversion is the falling edge of the shared BUSY/second-data pin. In dual-line mode that pin carries channels 4 to 7 while SDO carries channels 0 to 3, so the frame is half as long. The end of conversion is then assumed after a fixed cycle count.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, cnv_o and sck_o are low, cs_n_o is high, valid_o is low, and ch_data_o and cfg_rb_o are all zero.
- R2: A start_i pulse seen while no frame is active drives cnv_o high for exactly CNV_HIGH cycles, with cs_n_o high and sck_o low. A start_i that arrives during an active frame causes no second conversion pulse and does not change the configuration word being sent.
- R3: In single-line mode (dual_i=0 at start), cs_n_o falls on the first cycle in which both of these hold: a falling edge of busy_sdo2_i has been seen since the conversion pulse rose, and at least ACCESS_DLY cycles have passed since that rise. No sck_o edge occurs while the converter is busy.
- R4: In dual-line mode (dual_i=1 at start), busy_sdo2_i is not watched during conversion. cs_n_o falls CONV_CYCLES+1 cycles after cnv_o rises, given that CONV_CYCLES is at least ACCESS_DLY.
- R5: sck_o is low whenever cs_n_o is high. Each transferred word takes exactly 16 rising and 16 falling sck_o edges. SDO and the second data line are sampled on the rising edge of sck_o.
- R6: In single-line mode, 8 words arrive on sdo_i MSB first, in channel order 0 to 7. Channel k lands in ch_data_o[16*k+15:16*k].
- R7: In dual-line mode, 4 words are transferred. sdo_i supplies channels 0 to 3 and busy_sdo2_i supplies channels 4 to 7 at the same time, at the same bit positions as in R6.
- R8: With readback_i=1 at start, one extra 16-bit word on sdo_i follows the channel words and is stored in cfg_rb_o. With readback_i=0, no extra sck_o edges occur and cfg_rb_o keeps its previous value.
- R9: din_o carries cfg_i (captured at start) MSB first across the first 16 rising sck_o edges of the frame, and is low for the rest of the frame. din_o changes only on a falling sck_o edge, never while sck_o is high.
- R10: valid_o is high for exactly one cycle, in the cycle after the last falling sck_o edge, when cs_n_o has just returned high. ch_data_o and cfg_rb_o hold their values while cs_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame request, one cycle |
| cfg_i | input | WORD_W (16) | Configuration word to send in this frame |
| dual_i | input | 1 | 1 selects dual-line readout |
| readback_i | input | 1 | 1 adds the configuration readback word |
| cnv_o | output | 1 | Conversion start pulse to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| din_o | output | 1 | Serial configuration data to the converter |
| sdo_i | input | 1 | Primary serial data from the converter |
| busy_sdo2_i | input | 1 | BUSY in single-line mode, second data line in dual-line mode |
| ch_data_o | output | NCH*WORD_W (128) | Channel results, channel k in bits 16k+15..16k |
| cfg_rb_o | output | WORD_W (16) | Configuration readback word |
| valid_o | output | 1 | One-cycle frame-complete strobe |

## Verification
The assertions assume the following about the converter. In single-line mode it raises BUSY only in response to the conversion pulse and holds it low while data is being read. It changes its serial outputs only after an SCK falling edge. The bench models a converter that behaves this way. Its BUSY width can be set per test: a short width makes the access delay the binding limit, and a long width makes the BUSY edge the binding limit. All inputs are driven on the falling system-clock edge, and start requests are issued only from tasks that then wait for valid_o. The single exception is a deliberate mid-frame start that tests R2.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int NCH         = 8,
  parameter int WORD_W      = 16,
  parameter int CLK_DIV     = 4,
  parameter int CNV_HIGH    = 4,
  parameter int CONV_CYCLES = 200,
  parameter int ACCESS_DLY  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [WORD_W-1:0]       cfg_i,
  input  logic                    dual_i,
  input  logic                    readback_i,
  output logic                    cnv_o,
  output logic                    cs_n_o,
  output logic                    sck_o,
  output logic                    din_o,
  input  logic                    sdo_i,
  input  logic                    busy_sdo2_i,
  output logic [NCH*WORD_W-1:0]   ch_data_o,
  output logic [WORD_W-1:0]       cfg_rb_o,
  output logic                    valid_o
);
  localparam int HALF_CH = NCH / 2;
  localparam int TLIM    = (CONV_CYCLES > ACCESS_DLY) ?
                           ((CONV_CYCLES > CNV_HIGH) ? CONV_CYCLES : CNV_HIGH) :
                           ((ACCESS_DLY > CNV_HIGH) ? ACCESS_DLY : CNV_HIGH);
  localparam int TW      = $clog2(TLIM + 2);
  localparam int DW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW      = $clog2(WORD_W);
  localparam int WIW     = $clog2(NCH + 1);

  localparam logic [TW-1:0]  T_CNV  = TW'(CNV_HIGH);
  localparam logic [TW-1:0]  T_CONV = TW'(CONV_CYCLES);
  localparam logic [TW-1:0]  T_ACC  = TW'(ACCESS_DLY);
  localparam logic [TW-1:0]  T_MAX  = '1;
  localparam logic [DW-1:0]  D_TOP  = DW'(CLK_DIV - 1);
  localparam logic [BW-1:0]  B_TOP  = BW'(WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_XFER, S_DONE} st_t;

  st_t               st;
  logic [TW-1:0]     t;
  logic              eoc_q, busy_q, dual_q, rb_q, sck_q;
  logic [DW-1:0]     div;
  logic [BW-1:0]     bitn;
  logic [WIW-1:0]    word;
  logic [WORD_W-2:0] sh0, sh1;
  logic [WORD_W-1:0] cfg_sh;
  logic [WORD_W-1:0] ch_q [NCH];
  logic [WORD_W-1:0] rb_word;

  logic [WORD_W-1:0] new0, new1;
  logic [WIW-1:0]    n_data, last_word;
  logic              tick, rise, fall, eoc_now, go;

  assign new0      = {sh0, sdo_i};
  assign new1      = {sh1, busy_sdo2_i};
  assign n_data    = dual_q ? WIW'(HALF_CH) : WIW'(NCH);
  assign last_word = rb_q ? n_data : n_data - WIW'(1);
  assign tick      = (div == D_TOP);
  assign rise      = (st == S_XFER) && tick && !sck_q;
  assign fall      = (st == S_XFER) && tick && sck_q;
  assign eoc_now   = dual_q ? (t >= T_CONV) : (eoc_q || (busy_q && !busy_sdo2_i));
  assign go        = (st == S_CONV) && eoc_now && (t >= T_ACC) && (t >= T_CNV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      t       <= '0;
      eoc_q   <= 1'b0;
      busy_q  <= 1'b0;
      dual_q  <= 1'b0;
      rb_q    <= 1'b0;
      sck_q   <= 1'b0;
      div     <= '0;
      bitn    <= '0;
      word    <= '0;
      sh0     <= '0;
      sh1     <= '0;
      cfg_sh  <= '0;
      rb_word <= '0;
      for (int i = 0; i < NCH; i++) ch_q[i] <= '0;
    end else begin
      busy_q <= busy_sdo2_i;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            st     <= S_CONV;
            t      <= '0;
            eoc_q  <= 1'b0;
            dual_q <= dual_i;
            rb_q   <= readback_i;
            cfg_sh <= cfg_i;
          end
        end
        S_CONV: begin
          if (t != T_MAX) t <= t + TW'(1);
          if (!dual_q && busy_q && !busy_sdo2_i) eoc_q <= 1'b1;
          if (go) begin
            st    <= S_XFER;
            div   <= '0;
            sck_q <= 1'b0;
            bitn  <= '0;
            word  <= '0;
          end
        end
        S_XFER: begin
          div <= tick ? '0 : div + DW'(1);
          if (tick) sck_q <= ~sck_q;
          if (rise) begin
            sh0 <= new0[WORD_W-2:0];
            sh1 <= new1[WORD_W-2:0];
            if (bitn == B_TOP) begin
              for (int i = 0; i < NCH; i++) begin
                if (!dual_q && word == WIW'(i)) ch_q[i] <= new0;
                if (dual_q && i < HALF_CH && word == WIW'(i)) ch_q[i] <= new0;
                if (dual_q && i >= HALF_CH && word == WIW'(i - HALF_CH)) ch_q[i] <= new1;
              end
              if (word == n_data) rb_word <= new0;
            end
          end
          if (fall) begin
            cfg_sh <= {cfg_sh[WORD_W-2:0], 1'b0};
            if (bitn == B_TOP) begin
              bitn <= '0;
              word <= word + WIW'(1);
              if (word == last_word) st <= S_DONE;
            end else begin
              bitn <= bitn + BW'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cnv_o    = (st == S_CONV) && (t < T_CNV);
  assign cs_n_o   = (st != S_XFER);
  assign sck_o    = sck_q;
  assign din_o    = cfg_sh[WORD_W-1];
  assign valid_o  = (st == S_DONE);
  assign cfg_rb_o = rb_word;

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_data_o[g*WORD_W +: WORD_W] = ch_q[g];
  end
endmodule

module adc_scan_ctrl_chk #(
  parameter int NCH    = 8,
  parameter int WORD_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cnv_o,
  input logic                  cs_n_o,
  input logic                  sck_o,
  input logic                  din_o,
  input logic                  busy_sdo2_i,
  input logic                  dual_q,
  input logic                  valid_o,
  input logic [NCH*WORD_W-1:0] ch_data_o,
  input logic [WORD_W-1:0]     cfg_rb_o
);
  a_r2_cs_high_at_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> cs_n_o);
  a_r2_quiet_during_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> (cs_n_o && !sck_o));
  a_r3_no_access_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_q && busy_sdo2_i) |-> !$fell(cs_n_o));
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);
  a_r9_din_steady_high_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(din_o));
  a_r10_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r10_valid_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (cs_n_o && !$past(cs_n_o)));
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o)) |-> ($stable(ch_data_o) && $stable(cfg_rb_o)));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.NCH(NCH), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;
  localparam int CNV_HIGH   = 3;
  localparam int CONV_CYC   = 30;
  localparam int ACC_DLY    = 8;
  localparam logic [15:0] CFG_RST = 16'h0F0F;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dual = 1'b0, rb = 1'b0;
  logic [15:0] cfg = '0;
  logic cnv, cs_n, sck, din, sdo, sdo2;
  logic [127:0] ch_data;
  logic [15:0]  cfg_rb;
  logic valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_ctrl #(.NCH(8), .WORD_W(16), .CLK_DIV(CLK_DIV), .CNV_HIGH(CNV_HIGH),
                  .CONV_CYCLES(CONV_CYC), .ACCESS_DLY(ACC_DLY)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_i(cfg), .dual_i(dual),
    .readback_i(rb), .cnv_o(cnv), .cs_n_o(cs_n), .sck_o(sck), .din_o(din),
    .sdo_i(sdo), .busy_sdo2_i(sdo2), .ch_data_o(ch_data), .cfg_rb_o(cfg_rb),
    .valid_o(valid));

  int checks = 0, fails = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dval(int c, int ch);
    int v;
    v = (c * 40503 + ch * 4369) ^ 16'hA5C3;
    return v[15:0];
  endfunction

  // converter model
  bit dev_dual = 0;
  int dev_conv = 14;
  logic dev_busy = 1'b0;
  logic [143:0] st0 = '0, st1 = '0;
  int idx = 200, conv_id = 0, din_n = 0, din_ones_late = 0, busy_edges = 0, sck_rises = 0;
  logic [15:0] cfg_cur = CFG_RST, cfg_pend = CFG_RST, conv_cfg = '0, din_sh = '0, last_din = '0;

  assign sdo  = (idx < 144) ? st0[143-idx] : 1'b0;
  assign sdo2 = dev_dual ? ((idx < 144) ? st1[143-idx] : 1'b0) : dev_busy;

  always @(posedge cnv) begin
    conv_cfg = cfg_cur;
    conv_id++;
    if (!dev_dual) dev_busy = 1'b1;
    repeat (dev_conv) @(negedge clk);
    dev_busy = 1'b0;
    cfg_cur = cfg_pend;
    st0 = '0; st1 = '0;
    if (dev_dual) begin
      for (int k = 0; k < 4; k++) begin
        st0[143-16*k -: 16] = dval(conv_id, k);
        st1[143-16*k -: 16] = dval(conv_id, k+4);
      end
      st0[143-64 -: 16] = conv_cfg;
    end else begin
      for (int k = 0; k < 8; k++) st0[143-16*k -: 16] = dval(conv_id, k);
      st0[143-128 -: 16] = conv_cfg;
    end
  end

  always @(negedge cs_n) begin idx = 0; din_n = 0; end
  always @(negedge sck) if (!cs_n) idx++;
  always @(posedge sck) begin
    sck_rises++;
    if (dev_busy) busy_edges++;
    if (din_n < 16) begin din_sh = {din_sh[14:0], din}; din_n++; end
    else if (din) din_ones_late++;
  end
  always @(posedge cs_n) if (din_n >= 16) begin cfg_pend = din_sh; last_din = din_sh; end

  // edge monitor
  int cyc = 0, t_cr = 0, t_csf = 0, cnv_w = 0, vcnt = 0, cnv_rises = 0;
  logic p_cnv = 1'b0, p_cs = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (cnv && !p_cnv) begin t_cr = cyc; cnv_rises++; end
    if (!cnv && p_cnv) cnv_w = cyc - t_cr;
    if (!cs_n && p_cs) t_csf = cyc;
    if (valid) vcnt++;
    p_cnv = cnv; p_cs = cs_n;
  end

  // bench bookkeeping
  logic [15:0] hist [64];
  int nf = 0;
  logic [15:0] rb_exp = '0;

  function automatic logic [15:0] rb_expect(int k);
    return (k >= 3) ? hist[k-2] : CFG_RST;
  endfunction

  task automatic run_frame(logic [15:0] c, bit d, bit r);
    @(negedge clk);
    dev_dual = d; sck_rises = 0; vcnt = 0; cnv_rises = 0;
    busy_edges = 0; din_ones_late = 0;
    start = 1'b1; cfg = c; dual = d; rb = r;
    @(negedge clk);
    start = 1'b0;
    nf++; hist[nf] = c;
    while (!valid) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic check_common(logic [15:0] c, bit r, int words);
    chk("R2 cnv width", cnv_w, CNV_HIGH);
    chk("R2 one conversion per frame", cnv_rises, 1);
    chk("R5 sck rising edges", sck_rises, 16*(words + (r ? 1 : 0)));
    chk("R9 config word on din", last_din, c);
    chk("R9 din low after config", din_ones_late, 0);
    chk("R10 valid cycles", vcnt, 1);
    if (r) rb_exp = rb_expect(nf);
    chk(r ? "R8 readback word" : "R8 readback unchanged when off", cfg_rb, rb_exp);
  endtask

  task automatic t_reset();
    chk("R1 cnv low", cnv, 0);
    chk("R1 cs high", cs_n, 1);
    chk("R1 sck low", sck, 0);
    chk("R1 valid low", valid, 0);
    chk("R1 ch data zero", ch_data[31:0] | ch_data[127:96], 0);
    chk("R1 readback zero", cfg_rb, 0);
  endtask

  task automatic t_single(logic [15:0] c, bit r, int dconv);
    dev_conv = dconv;
    run_frame(c, 1'b0, r);
    for (int k = 0; k < 8; k++) chk("R6 single-line channel", ch_data[16*k +: 16], dval(nf, k));
    chk("R3 no sck while busy", busy_edges, 0);
    chk("R3 access latency", t_csf - t_cr, (dconv > ACC_DLY) ? dconv : ACC_DLY + 1);
    check_common(c, r, 8);
  endtask

  task automatic t_dual(logic [15:0] c, bit r);
    dev_conv = 14;
    run_frame(c, 1'b1, r);
    for (int k = 0; k < 8; k++) chk("R7 dual-line channel", ch_data[16*k +: 16], dval(nf, k));
    chk("R4 fixed conversion wait", t_csf - t_cr, CONV_CYC + 1);
    check_common(c, r, 4);
  endtask

  task automatic t_mid_start();
    dev_conv = 14;
    @(negedge clk);
    dev_dual = 0; vcnt = 0; cnv_rises = 0;
    start = 1'b1; cfg = 16'h3C96; dual = 0; rb = 0;
    @(negedge clk);
    start = 1'b0;
    nf++; hist[nf] = 16'h3C96;
    while (cs_n) @(negedge clk);
    repeat (5) @(negedge clk);
    start = 1'b1; cfg = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    while (!valid) @(negedge clk);
    @(negedge clk); @(negedge clk);
    chk("R2 mid-frame start gives no pulse", cnv_rises, 1);
    chk("R2 mid-frame start keeps config", last_din, 16'h3C96);
    chk("R10 valid cycles", vcnt, 1);
  endtask

  task automatic t_hold();
    logic [127:0] d0;
    logic [15:0] r0;
    d0 = ch_data; r0 = cfg_rb; cnv_rises = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfg = 16'(k * 777); dual = k[0]; rb = k[1];
    end
    chk("R10 data held between frames", {96'b0, ch_data[31:0] ^ d0[31:0]} | (ch_data ^ d0), 0);
    chk("R10 readback held", cfg_rb, r0);
    chk("R2 no conversion without start", cnv_rises, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single(16'hA1B2, 1'b1, 14);
    t_single(16'h1357, 1'b0, 2);
    t_single(16'hC0DE, 1'b1, 14);
    t_dual(16'h5AA5, 1'b1);
    t_dual(16'h0001, 1'b0);
    t_hold();
    t_mid_start();
    t_single(16'h8000, 1'b1, 2);
    t_dual(16'h7E81, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule